// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Identification Register

This block is the serial test port of a memory device. Four wires drive it: a test clock, a mode-select line, serial data in and serial data out. It has no dedicated test-reset pin. The standard sixteen-state controller decodes the mode-select line, and a three-bit instruction picks which shift register sits between serial in and serial out. The candidates are a one-stage bypass, a 32-bit identification word and a boundary register. The boundary register's length is a parameter.

The boundary register talks to the core through two parallel buses. One is a capture bus, which the register samples. The other is an update bus, which holds the last value that was shifted in. Two mode outputs tell the pad logic what to do. One says to drive the update bus onto the pins. The other says to float the data outputs while the boundary register is being scanned. The pad cells themselves live outside this block.

Inputs are sampled on the rising test-clock edge. Serial out changes only on the falling edge. A power-on reset input brings the port to its idle reset state.

Top module: `scan_tap`

## Requirements
- R1: While the power-on reset `rstN` is low, the controller is held in Test-Logic-Reset and the instruction is IDCODE. In that state `tdoEn`, `outHiZ` and `extestMode` are low and `bsrUpdOut` is all zero. A data scan taken right after release returns the identification word.
- R2: Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any controller state. This reloads the instruction with IDCODE (code 001).
- R3: Capture-IR loads binary 001 into the instruction shift stage. A following Shift-IR presents it on `tdo` least significant bit first, giving 1, 0, 0.
- R4: Under IDCODE (001), Capture-DR loads a 32-bit word and Shift-DR shifts it out least significant bit first. The word holds the revision parameter in bits 31:29, the type parameter in bits 28:12, the vendor parameter in bits 11:1, and a 1 in bit 0.
- R5: Under BYPASS (111), Capture-DR clears a single stage. Each `tdi` bit appears on `tdo` one shift later.
- R6: The unused codes 011, 101 and 110 select the bypass stage. They raise neither `outHiZ` nor `extestMode`.
- R7: Under SAMPLE/PRELOAD (100), Capture-DR loads `bsrCapIn`. Shift-DR moves the boundary register toward bit 0: bit 0 goes to `tdo` and `tdi` enters at the top bit. Update-DR copies the shift stage to `bsrUpdOut`.
- R8: Under EXTEST (000), `extestMode` is high from the Update-IR that loads the instruction. `bsrUpdOut` keeps the value preloaded earlier until the next Update-DR.
- R9: Under SAMPLE-Z (010), `outHiZ` is high from Update-IR on, and the boundary register is the one between `tdi` and `tdo`.
- R10: `tdoEn` is high only while the controller is in Shift-DR or Shift-IR. `tdo` changes only on a falling `tck` edge.
- R11: `bsrUpdOut` changes only at Update-DR while a boundary instruction (000, 010, 100) is active. Scans under other instructions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdoEn | output | 1 | Drive enable for `tdo`, high only in the shift states |
| bsrCapIn | input | BSR_LEN | Core values captured by the boundary register |
| bsrUpdOut | output | BSR_LEN | Update stage of the boundary register, toward the pads |
| extestMode | output | 1 | High while EXTEST is the active instruction |
| outHiZ | output | 1 | High while SAMPLE-Z is active; forces data outputs to high impedance |

## Verification
The bench walks the controller into each of its other fifteen states and then applies five `tms` ones. A controller with a wrong arc, or one that needs more ones, would stay outside reset and return a bypass bit where the identification word is expected. Every instruction code, including the three unused ones, is loaded and scanned. An incomplete decode would put the wrong register on `tdo`, or would raise a pad-mode output for a code that should not touch the pads. The boundary sequence is preload, then EXTEST, then SAMPLE-Z, then BYPASS. It would expose an update stage that follows the shift stage directly, or one that is written under a non-boundary instruction. `tdo` is also sampled just after a rising edge, so a design that drives serial out on the wrong edge is reported.

// File: rtl/scan_tap_pkg.sv
`timescale 1ns/1ps
package scan_tap_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tapState_e;

  typedef enum logic [1:0] {
    DR_BYPASS   = 2'd0,
    DR_IDENT    = 2'd1,
    DR_BOUNDARY = 2'd2
  } drSel_e;

  typedef struct packed {
    logic   capDr;
    logic   shiftDr;
    logic   updDr;
    logic   shiftIr;
    drSel_e drSel;
  } tapStrobe_t;

endpackage

// File: rtl/scan_tap_ctrl.sv
`timescale 1ns/1ps
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rstN,
  input  logic            tms,
  input  logic            tdi,
  output tapState_e       state,
  output tapStrobe_t      strobe,
  output logic            irTdo,
  output logic [IR_W-1:0] irCode,
  output logic            outHiZ,
  output logic            extestMode
);

  tapState_e       nextState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irReg;
  drSel_e          drSel;

  // state transitions of the standard controller
  always_comb begin
    case (state)
      ST_TLR:    nextState = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nextState = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_RTI;
      default:   nextState = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) state <= ST_TLR;
    else       state <= nextState;
  end

  // instruction shift stage and active instruction
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      irShift <= IR_CAPTURE;
      irReg   <= OP_IDCODE;
    end else begin
      case (state)
        ST_CAP_IR: irShift <= IR_CAPTURE;
        ST_SH_IR:  irShift <= {tdi, irShift[IR_W-1:1]};
        default:   irShift <= irShift;
      endcase
      if (state == ST_TLR)         irReg <= OP_IDCODE;
      else if (state == ST_UPD_IR) irReg <= irShift;
    end
  end

  // data register selection; unused codes fall to bypass
  always_comb begin
    case (irReg)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: drSel = DR_BOUNDARY;
      OP_IDCODE:                        drSel = DR_IDENT;
      default:                          drSel = DR_BYPASS;
    endcase
  end

  assign strobe.capDr   = (state == ST_CAP_DR);
  assign strobe.shiftDr = (state == ST_SH_DR);
  assign strobe.updDr   = (state == ST_UPD_DR);
  assign strobe.shiftIr = (state == ST_SH_IR);
  assign strobe.drSel   = drSel;

  assign irTdo      = irShift[0];
  assign irCode     = irReg;
  assign outHiZ     = (irReg == OP_SAMPLEZ);
  assign extestMode = (irReg == OP_EXTEST);

endmodule

// File: rtl/scan_tap_dpath.sv
`timescale 1ns/1ps
module scan_tap_dpath
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN = 109,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic               tdi,
  input  tapStrobe_t         strobe,
  input  logic               irTdo,
  input  logic [BSR_LEN-1:0] bsrCapIn,
  output logic [BSR_LEN-1:0] bsrUpdOut,
  output logic               tdo,
  output logic               tdoEn
);

  localparam int ID_W = 32;

  logic               bypassBit;
  logic [ID_W-1:0]    idShift;
  logic [BSR_LEN-1:0] bsrShift;
  logic [BSR_LEN-1:0] bsrShiftNext;
  logic [BSR_LEN-1:0] bsrUpd;
  logic               selBsr;
  logic               selId;
  logic               selByp;
  logic               drOut;

  assign selBsr = (strobe.drSel == DR_BOUNDARY);
  assign selId  = (strobe.drSel == DR_IDENT);
  assign selByp = (strobe.drSel == DR_BYPASS);

  // boundary shift chain: each cell takes its upper neighbour, the top takes tdi
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (i == BSR_LEN - 1) begin : g_top
      assign bsrShiftNext[i] = tdi;
    end else begin : g_mid
      assign bsrShiftNext[i] = bsrShift[i+1];
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      bypassBit <= 1'b0;
      idShift   <= '0;
      bsrShift  <= '0;
      bsrUpd    <= '0;
    end else begin
      if (selByp) begin
        if (strobe.capDr)        bypassBit <= 1'b0;
        else if (strobe.shiftDr) bypassBit <= tdi;
      end
      if (selId) begin
        if (strobe.capDr)        idShift <= ID_WORD;
        else if (strobe.shiftDr) idShift <= {tdi, idShift[ID_W-1:1]};
      end
      if (selBsr) begin
        if (strobe.capDr)        bsrShift <= bsrCapIn;
        else if (strobe.shiftDr) bsrShift <= bsrShiftNext;
        if (strobe.updDr)        bsrUpd   <= bsrShift;
      end
    end
  end

  always_comb begin
    case (strobe.drSel)
      DR_IDENT:    drOut = idShift[0];
      DR_BOUNDARY: drOut = bsrShift[0];
      default:     drOut = bypassBit;
    endcase
  end

  // serial output moves on the falling edge
  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strobe.shiftDr | strobe.shiftIr;
      tdo   <= strobe.shiftIr ? irTdo : drOut;
    end
  end

  assign bsrUpdOut = bsrUpd;

endmodule

// File: rtl/scan_tap.sv
`timescale 1ns/1ps
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN   = 109,
  parameter logic [2:0]  ID_REV    = 3'h2,
  parameter logic [16:0] ID_TYPE   = 17'h0A5C3,
  parameter logic [10:0] ID_VENDOR = 11'h04B
) (
  input  logic               tck,
  input  logic               rstN,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdoEn,
  input  logic [BSR_LEN-1:0] bsrCapIn,
  output logic [BSR_LEN-1:0] bsrUpdOut,
  output logic               extestMode,
  output logic               outHiZ
);

  localparam logic [31:0] ID_WORD = {ID_REV, ID_TYPE, ID_VENDOR, 1'b1};

  tapState_e       curState;
  tapStrobe_t      strobe;
  logic            irTdo;
  logic [IR_W-1:0] irCode;

  scan_tap_ctrl u_ctrl (
    .tck        (tck),
    .rstN       (rstN),
    .tms        (tms),
    .tdi        (tdi),
    .state      (curState),
    .strobe     (strobe),
    .irTdo      (irTdo),
    .irCode     (irCode),
    .outHiZ     (outHiZ),
    .extestMode (extestMode)
  );

  scan_tap_dpath #(
    .BSR_LEN (BSR_LEN),
    .ID_WORD (ID_WORD)
  ) u_dpath (
    .tck       (tck),
    .rstN      (rstN),
    .tdi       (tdi),
    .strobe    (strobe),
    .irTdo     (irTdo),
    .bsrCapIn  (bsrCapIn),
    .bsrUpdOut (bsrUpdOut),
    .tdo       (tdo),
    .tdoEn     (tdoEn)
  );

endmodule

// File: rtl/scan_tap_chk.sv
`timescale 1ns/1ps
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int BSR_LEN = 109
) (
  input logic               tck,
  input logic               rstN,
  input logic               tms,
  input tapState_e          state,
  input logic [IR_W-1:0]    irCode,
  input logic               tdoEn,
  input logic               outHiZ,
  input logic               extestMode,
  input logic [BSR_LEN-1:0] bsrUpdOut
);

  logic [2:0] onesCnt;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)   onesCnt <= '0;
    else if (tms) onesCnt <= (onesCnt == 3'd5) ? 3'd5 : onesCnt + 3'd1;
    else         onesCnt <= '0;
  end

  // R2
  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!rstN)
    (onesCnt == 3'd5) |-> (state == ST_TLR));

  // R1
  a_r1_reset_idcode: assert property (@(posedge tck) disable iff (!rstN)
    (state == ST_TLR) |=> (irCode == OP_IDCODE));

  // R10
  a_r10_tdoen_shift: assert property (@(posedge tck) disable iff (!rstN)
    tdoEn == ((state == ST_SH_DR) || (state == ST_SH_IR)));

  // R9
  a_r9_hiz_from_update: assert property (@(posedge tck) disable iff (!rstN)
    $rose(outHiZ) |-> ($past(state) == ST_UPD_IR));

  // R8
  a_r8_extest_from_update: assert property (@(posedge tck) disable iff (!rstN)
    $rose(extestMode) |-> ($past(state) == ST_UPD_IR));

  // R11
  a_r11_update_only: assert property (@(posedge tck) disable iff (!rstN)
    !$stable(bsrUpdOut) |-> ($past(state) == ST_UPD_DR));

endmodule

bind scan_tap scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck        (tck),
  .rstN       (rstN),
  .tms        (tms),
  .state      (curState),
  .irCode     (irCode),
  .tdoEn      (tdoEn),
  .outHiZ     (outHiZ),
  .extestMode (extestMode),
  .bsrUpdOut  (bsrUpdOut)
);

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;

  localparam int          LEN  = 109;
  localparam logic [2:0]  REV  = 3'h2;
  localparam logic [16:0] TYP  = 17'h0A5C3;
  localparam logic [10:0] VEND = 11'h04B;

  logic           tck = 1'b0;
  logic           rstN = 1'b0;
  logic           tms = 1'b1;
  logic           tdi = 1'b0;
  logic           tdo;
  logic           tdoEn;
  logic [LEN-1:0] bsrCapIn = '0;
  logic [LEN-1:0] bsrUpdOut;
  logic           extestMode;
  logic           outHiZ;

  int checks = 0;
  int errors = 0;

  always #2.5 tck = ~tck;

  scan_tap u_scan_tap (
    .tck(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .bsrCapIn(bsrCapIn), .bsrUpdOut(bsrUpdOut),
    .extestMode(extestMode), .outHiZ(outHiZ)
  );

  function automatic logic [127:0] expId();
    longint v;
    v = longint'(REV) * 64'd536870912 + longint'(TYP) * 64'd4096 + longint'(VEND) * 64'd2 + 64'd1;
    return 128'(v);
  endfunction

  function automatic logic [127:0] pattern(input int seed);
    logic [127:0] p = '0;
    for (int i = 0; i < LEN; i++) p[i] = (((i * seed) + (i / 3) + seed) % 5) < 2;
    return p;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic tmsV, input logic tdiV);
    tms = tmsV;
    tdi = tdiV;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic loadIr(input logic [2:0] code, output logic [2:0] capt);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    capt[0] = tdo;
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i]);
      if (i < 2) capt[i+1] = tdo;
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scanDr(input int n, input logic [127:0] din, output logic [127:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    dout[0] = tdo;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = tdo;
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0]   capt;
    logic [127:0] dout;
    logic [127:0] pa, pb, pc, pd;
    string        paths [15];
    paths = '{"", "1", "10", "100", "1001", "10010", "100101", "10011",
              "11", "110", "1100", "11001", "110010", "1100101", "11011"};

    @(negedge tck); @(negedge tck); #1;
    chk("R1 tdoEn in reset", 128'(tdoEn), 128'd0);
    chk("R1 outHiZ in reset", 128'(outHiZ), 128'd0);
    chk("R1 extestMode in reset", 128'(extestMode), 128'd0);
    chk("R1 update reg in reset", 128'(bsrUpdOut), 128'd0);
    rstN = 1'b1;
    tick(0, 0);
    scanDr(32, 128'h0, dout);
    chk("R1 R4 id after power-on", dout, expId());

    // R3 instruction capture pattern
    loadIr(3'b111, capt);
    chk("R3 ir capture", 128'(capt), 128'd1);

    // R5 bypass, with R10 edge checks
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R10 tdoEn in shift", 128'(tdoEn), 128'd1);
    chk("R5 bypass captured zero", 128'(tdo), 128'd0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R10 tdo held at rising edge", 128'(tdo), 128'd0);
    @(negedge tck); #1;
    chk("R5 bypass one-stage delay", 128'(tdo), 128'd1);
    tick(1, 0); tick(1, 0); tick(0, 0);
    chk("R10 tdoEn idle", 128'(tdoEn), 128'd0);
    pa = 128'hA5;
    scanDr(8, pa, dout);
    chk("R5 bypass stream", dout, {pa[126:0], 1'b0} & 128'hFF);

    // R6 unused codes behave as bypass
    for (int k = 0; k < 3; k++) begin
      logic [2:0] code;
      code = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
      loadIr(code, capt);
      chk("R3 ir capture", 128'(capt), 128'd1);
      pa = 128'(8'h3C ^ (k * 8'h11));
      scanDr(8, pa, dout);
      chk("R6 unused code acts as bypass", dout, {pa[126:0], 1'b0} & 128'hFF);
      chk("R6 unused code pad modes", 128'({outHiZ, extestMode}), 128'd0);
    end

    // R7 sample / preload
    pa = pattern(3); pb = pattern(7); pc = pattern(11); pd = pattern(13);
    bsrCapIn = pa[LEN-1:0];
    loadIr(3'b100, capt);
    chk("R7 sample pad modes", 128'({outHiZ, extestMode}), 128'd0);
    scanDr(LEN, pb, dout);
    chk("R7 sample capture", dout, pa);
    chk("R7 preload update", 128'(bsrUpdOut), pb);

    // R8 extest
    loadIr(3'b000, capt);
    chk("R8 extest mode", 128'(extestMode), 128'd1);
    chk("R8 preload retained", 128'(bsrUpdOut), pb);
    bsrCapIn = pd[LEN-1:0];
    scanDr(LEN, pc, dout);
    chk("R8 extest capture", dout, pd);
    chk("R8 extest update", 128'(bsrUpdOut), pc);

    // R9 sample-z
    loadIr(3'b010, capt);
    chk("R9 outHiZ", 128'(outHiZ), 128'd1);
    chk("R9 extest off", 128'(extestMode), 128'd0);
    bsrCapIn = pb[LEN-1:0];
    scanDr(LEN, pa, dout);
    chk("R9 boundary scanned", dout, pb);
    chk("R9 update", 128'(bsrUpdOut), pa);

    // R11 non-boundary scan leaves update stage alone
    loadIr(3'b111, capt);
    chk("R11 outHiZ cleared", 128'(outHiZ), 128'd0);
    scanDr(16, 128'hBEEF, dout);
    chk("R11 update unchanged", 128'(bsrUpdOut), pa);
    loadIr(3'b001, capt);
    scanDr(32, 128'h0, dout);
    chk("R4 idcode instruction", dout, expId());
    chk("R11 update unchanged after id", 128'(bsrUpdOut), pa);

    // R2 five ones from each state
    foreach (paths[p]) begin
      loadIr(3'b111, capt);
      for (int j = 0; j < paths[p].len(); j++) tick(paths[p].getc(j) == 8'h31, 1'b1);
      for (int j = 0; j < 5; j++) tick(1, 0);
      chk("R2 tdoEn after reset walk", 128'(tdoEn), 128'd0);
      tick(0, 0);
      scanDr(32, 128'h0, dout);
      chk("R2 idcode after five ones", dout, expId());
    end

    // R1 power-on reset mid-operation
    loadIr(3'b010, capt);
    rstN = 1'b0; #1;
    chk("R1 async reset hiz", 128'(outHiZ), 128'd0);
    chk("R1 async reset update", 128'(bsrUpdOut), 128'd0);
    @(negedge tck); #1;
    rstN = 1'b1;
    tick(0, 0);
    scanDr(32, 128'h0, dout);
    chk("R1 idcode after reset", dout, expId());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule